// File: doc/BRIEF.md
# Configurable Single-Port Block RAM

This block is a synthesizable behavioural model of one on-chip single-port RAM. It has one rising-edge clock, a clock enable that qualifies both reading and writing, a write enable, and one write enable for each byte lane. It also has a single address, a write-data bus and a registered read-data bus. The total storage is fixed. The data width is a parameter, and the address narrows as the word grows, so the capacity stays at 2^14 data bits, not counting the ninth bit of each lane.

A second parameter chooses what the read register shows in a write cycle. It can keep its old value, show the word just written, or show the word the write replaced. A third parameter chooses how the read register clears to zero: synchronously on a clock edge, or asynchronously as soon as reset rises. Reset acts only on the read register and never on the stored words. Designs instantiate the block wherever a single-ported on-chip memory of a given shape is needed.

Top module: `spram_block`

## Requirements
- R1: DATA_W may be 1, 2, 4, 9, 18 or 36, and any other value stops elaboration. The address width is 14 − log2(P), where P is DATA_W for widths below 9 and 8·DATA_W/9 for the others. This gives 9 address bits at width 36 and 12 at width 4. Every address from 0 up to the top one selects a distinct word.
- R2: On a rising edge with ce=1 and we=1, the word at addr takes wr_data in every enabled lane.
- R3: Widths of 9 and more are split into 9-bit lanes, and be bit k gates bits 9k+8..9k. At widths below 9, be is one bit that gates the whole word. Lanes whose enable is 0 keep their stored value.
- R4: A rising edge with ce=1 and we=0 loads the word at addr into rd_data, one cycle after the address is presented.
- R5: With WR_MODE=WM_HOLD (0), rd_data does not change in a write cycle.
- R6: With WR_MODE=WM_THROUGH (1), after a write cycle rd_data holds the updated word. That word is wr_data in the enabled lanes and the prior contents in the other lanes.
- R7: With WR_MODE=WM_OLD (2), after a write cycle rd_data holds the contents the word had before that edge.
- R8: With ce=0, no word is written and rd_data holds, unless reset applies.
- R9: With ASYNC_RST=0, a rising edge with rst=1 clears rd_data to zero whatever ce is. In both reset modes, rst leaves the stored words untouched, and a write presented during reset still stores.
- R10: With ASYNC_RST=1, rd_data goes to zero as soon as rst rises, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Active-high reset of the read register |
| ce | input | 1 | Clock enable for reads and writes |
| we | input | 1 | Write enable |
| be | input | BE_W | Per-lane write enable (DATA_W/9, or 1 below width 9) |
| addr | input | AW | Word address |
| wr_data | input | DATA_W | Write data |
| rd_data | output | DATA_W | Registered read data |

## Verification
The bench drives one stimulus into four instances: the hold, write-through and read-old modes at width 36, and a narrow write-through copy at width 4. It compares each of them against its own reference memory. It targets partial-lane writes that must merge with stored data, since a lane-mask error corrupts the neighbouring lanes or drops the write. It also checks back-to-back writes to one address, where a read-old design that forwards new data instead of stored data fails. It checks writes while ce is low, which must neither store nor disturb the output. On the reset side, it checks that a synchronous clear happens even with ce low, that an asynchronous clear happens between clock edges, and that writes presented during reset are kept. The top and bottom addresses of the narrow instance catch an address width that is wrong for the port width.

// File: rtl/spram_pkg.sv
package spram_pkg;

   typedef enum logic [1:0] {
      WM_HOLD    = 2'd0,
      WM_THROUGH = 2'd1,
      WM_OLD     = 2'd2
   } wr_mode_e;

   localparam int unsigned LANE_BITS = 9;

   function automatic bit width_ok(input int unsigned w);
      return (w == 1) || (w == 2) || (w == 4) || (w == 9) || (w == 18) || (w == 36);
   endfunction

   function automatic int unsigned lane_count(input int unsigned w);
      return (w >= LANE_BITS) ? (w / LANE_BITS) : 1;
   endfunction

   function automatic int unsigned lane_width(input int unsigned w);
      return (w >= LANE_BITS) ? LANE_BITS : w;
   endfunction

   function automatic int unsigned payload_bits(input int unsigned w);
      return (w >= LANE_BITS) ? (w / LANE_BITS) * 8 : w;
   endfunction

   function automatic int unsigned addr_bits(input int unsigned base_aw, input int unsigned w);
      return base_aw - $clog2(payload_bits(w));
   endfunction

endpackage

// File: rtl/spram_lane.sv
module spram_lane #(
   parameter int unsigned LW = 9,
   parameter int unsigned AW = 9
) (
   input  logic          clk,
   input  logic          wr_en,
   input  logic [AW-1:0] addr,
   input  logic [LW-1:0] din,
   output logic [LW-1:0] dout
);
   localparam int unsigned DEPTH = 1 << AW;

   logic [LW-1:0] store [DEPTH];

   // combinational view of the addressed word before this edge's write
   assign dout = store[addr];

   always_ff @(posedge clk) begin
      if (wr_en) begin
         store[addr] <= din;
      end
   end

   // a lane that is not enabled must keep its addressed word
   AST_LANE_KEEP: assert property (@(posedge clk)
      !wr_en ##1 $stable(addr) |-> $stable(dout))
      else $error("lane changed without enable"); // R3

endmodule

// File: rtl/spram_next_sel.sv
module spram_next_sel
   import spram_pkg::*;
#(
   parameter int unsigned W       = 36,
   parameter wr_mode_e    WR_MODE = WM_THROUGH
) (
   input  logic         ce,
   input  logic         we,
   input  logic [W-1:0] lane_mask,
   input  logic [W-1:0] stored,
   input  logic [W-1:0] wr_data,
   output logic         load,
   output logic [W-1:0] nxt
);
   logic [W-1:0] merged;

   assign merged = (wr_data & lane_mask) | (stored & ~lane_mask);

   generate
      if (WR_MODE == WM_HOLD) begin : g_hold
         assign load = ce & ~we;
         assign nxt  = stored;
      end else if (WR_MODE == WM_THROUGH) begin : g_through
         assign load = ce;
         assign nxt  = we ? merged : stored;
      end else begin : g_old
         assign load = ce;
         assign nxt  = stored;
      end
   endgenerate

endmodule

// File: rtl/spram_outreg.sv
module spram_outreg #(
   parameter int unsigned W         = 36,
   parameter bit          ASYNC_RST = 1'b0
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         load,
   input  logic [W-1:0] nxt,
   output logic [W-1:0] q
);
   generate
      if (ASYNC_RST) begin : g_async
         always_ff @(posedge clk or posedge rst) begin
            if (rst) begin
               q <= '0;
            end else if (load) begin
               q <= nxt;
            end
         end
      end else begin : g_sync
         always_ff @(posedge clk) begin
            if (rst) begin
               q <= '0;
            end else if (load) begin
               q <= nxt;
            end
         end
      end
   endgenerate

   logic rst_q;

   always_ff @(posedge clk) begin
      rst_q <= rst;
      if (rst_q) begin
         AST_RST_CLEARS: assert (q == '0) else $error("read register not cleared"); // R9
      end
   end

endmodule

// File: rtl/spram_block.sv
module spram_block
   import spram_pkg::*;
#(
   parameter int unsigned DATA_W    = 36,
   parameter int unsigned BASE_AW   = 14,
   parameter wr_mode_e    WR_MODE   = WM_THROUGH,
   parameter bit          ASYNC_RST = 1'b0,
   localparam int unsigned BE_W     = lane_count(DATA_W),
   localparam int unsigned AW       = addr_bits(BASE_AW, DATA_W)
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              ce,
   input  logic              we,
   input  logic [BE_W-1:0]   be,
   input  logic [AW-1:0]     addr,
   input  logic [DATA_W-1:0] wr_data,
   output logic [DATA_W-1:0] rd_data
);
   localparam int unsigned LW = lane_width(DATA_W);

   // elaboration checks
   generate
      if (!width_ok(DATA_W)) begin : g_bad_width
         $error("DATA_W must be 1, 2, 4, 9, 18 or 36"); // R1
      end
      if (BE_W * LW != DATA_W) begin : g_bad_split
         $error("lane split does not cover the word"); // R1
      end
      if (AW < 1) begin : g_bad_aw
         $error("BASE_AW too small for DATA_W"); // R1
      end
   endgenerate

   logic [DATA_W-1:0] stored;
   logic [DATA_W-1:0] lane_mask;
   logic              load;
   logic [DATA_W-1:0] nxt;

   generate
      for (genvar l = 0; l < BE_W; l++) begin : g_lane
         logic lane_we;
         assign lane_we = ce & we & be[l];
         assign lane_mask[l*LW +: LW] = {LW{be[l]}};

         spram_lane #(
            .LW (LW),
            .AW (AW)
         ) u_lane (
            .clk   (clk),
            .wr_en (lane_we),
            .addr  (addr),
            .din   (wr_data[l*LW +: LW]),
            .dout  (stored[l*LW +: LW])
         );
      end
   endgenerate

   spram_next_sel #(
      .W       (DATA_W),
      .WR_MODE (WR_MODE)
   ) u_sel (
      .ce        (ce),
      .we        (we),
      .lane_mask (lane_mask),
      .stored    (stored),
      .wr_data   (wr_data),
      .load      (load),
      .nxt       (nxt)
   );

   spram_outreg #(
      .W         (DATA_W),
      .ASYNC_RST (ASYNC_RST)
   ) u_out (
      .clk  (clk),
      .rst  (rst),
      .load (load),
      .nxt  (nxt),
      .q    (rd_data)
   );

   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
      !ce |=> $stable(rd_data))
      else $error("output moved with ce low"); // R8

   generate
      if (WR_MODE == WM_HOLD) begin : g_chk_hold
         AST_WRITE_HOLD: assert property (@(posedge clk) disable iff (rst)
            (ce && we) |=> $stable(rd_data))
            else $error("hold mode output moved on write"); // R5
      end else if (WR_MODE == WM_THROUGH) begin : g_chk_through
         AST_WRITE_THROUGH: assert property (@(posedge clk) disable iff (rst)
            (ce && we && (&be)) |=> (rd_data == $past(wr_data)))
            else $error("write-through output mismatch"); // R6
      end else begin : g_chk_old
         AST_READ_OLD: assert property (@(posedge clk) disable iff (rst)
            (ce && we && (&be)) ##1 (ce && we && (&be) && $stable(addr))
            |=> (rd_data == $past(wr_data, 2)))
            else $error("read-old output mismatch"); // R7
      end
   endgenerate

endmodule

// File: tb/spram_block_tb.sv
module spram_block_tb;
   import spram_pkg::*;

   localparam int CLK_PERIOD = 10;
   localparam int W  = 36;
   localparam int AW = 9;
   localparam int WN  = 4;
   localparam int AWN = 12;

   logic clk = 1'b0;
   always #(CLK_PERIOD/2) clk = ~clk;

   logic           rst = 1'b1, ce = 1'b0, we = 1'b0;
   logic [3:0]     be = '0;
   logic [AW-1:0]  addr = '0;
   logic [W-1:0]   wd = '0;
   logic [AWN-1:0] addr_n = '0;
   logic [WN-1:0]  wd_n = '0;
   logic [W-1:0]   q_thr, q_old, q_hold;
   logic [WN-1:0]  q_n;

   spram_block #(.DATA_W(W), .WR_MODE(WM_THROUGH), .ASYNC_RST(1'b0)) u_dut (
      .clk(clk), .rst(rst), .ce(ce), .we(we), .be(be), .addr(addr), .wr_data(wd), .rd_data(q_thr));
   spram_block #(.DATA_W(W), .WR_MODE(WM_OLD), .ASYNC_RST(1'b1)) u_dut_old (
      .clk(clk), .rst(rst), .ce(ce), .we(we), .be(be), .addr(addr), .wr_data(wd), .rd_data(q_old));
   spram_block #(.DATA_W(W), .WR_MODE(WM_HOLD), .ASYNC_RST(1'b0)) u_dut_hold (
      .clk(clk), .rst(rst), .ce(ce), .we(we), .be(be), .addr(addr), .wr_data(wd), .rd_data(q_hold));
   spram_block #(.DATA_W(WN), .WR_MODE(WM_THROUGH), .ASYNC_RST(1'b1)) u_dut_n (
      .clk(clk), .rst(rst), .ce(ce), .we(we), .be(be[0]), .addr(addr_n), .wr_data(wd_n), .rd_data(q_n));

   typedef struct {
      logic [W-1:0]  e_thr, e_old, e_hold;
      logic [WN-1:0] e_n;
      bit            v_thr, v_old, v_hold, v_n;
      string         tag;
   } exp_t;

   exp_t scb[$];
   int checks = 0, errors = 0;

   // reference state
   logic [W-1:0]  m36 [1<<AW];
   bit            k36 [1<<AW];
   logic [WN-1:0] mn  [1<<AWN];
   bit            kn  [1<<AWN];
   logic [W-1:0]  r_thr = '0, r_old = '0, r_hold = '0;
   logic [WN-1:0] r_n = '0;
   bit            v_thr = 1, v_old = 1, v_hold = 1, v_n = 1;

   task automatic check36(string tag, string who, logic [W-1:0] act, logic [W-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual %h expected %h", tag, who, act, exp);
      end
   endtask

   // monitor: compares the output produced by the most recent edge
   always @(negedge clk) begin
      if (scb.size() > 0) begin
         exp_t e;
         e = scb.pop_front();
         if (e.v_thr)  check36(e.tag, "through", q_thr, e.e_thr);
         if (e.v_old)  check36(e.tag, "old", q_old, e.e_old);
         if (e.v_hold) check36(e.tag, "hold", q_hold, e.e_hold);
         if (e.v_n)    check36(e.tag, "narrow", {32'd0, q_n}, {32'd0, e.e_n});
      end
   end

   // driver: applies one cycle and pushes the expected result
   task automatic op(input logic r, input logic c, input logic w, input logic [3:0] b,
                     input logic [AW-1:0] a, input logic [W-1:0] d,
                     input logic [AWN-1:0] an, input logic [WN-1:0] dn, input string tag);
      logic [W-1:0] mask, prev, merged;
      logic [WN-1:0] prevn;
      bit kp, kpn;
      exp_t e;
      @(negedge clk);
      rst = r; ce = c; we = w; be = b; addr = a; wd = d; addr_n = an; wd_n = dn;
      @(posedge clk);
      #1;
      for (int l = 0; l < 4; l++) mask[l*9 +: 9] = {9{b[l]}};
      prev = m36[a]; kp = k36[a]; prevn = mn[an]; kpn = kn[an];
      merged = (d & mask) | (prev & ~mask);
      if (c && w) begin
         m36[a] = merged; k36[a] = kp || (&b);
         if (b[0]) begin mn[an] = dn; kn[an] = 1; end
      end
      if (r) begin
         r_thr = '0; r_old = '0; r_hold = '0; r_n = '0;
         v_thr = 1; v_old = 1; v_hold = 1; v_n = 1;
      end else if (c) begin
         if (w) begin
            r_thr = merged; v_thr = kp || (&b);
            r_old = prev;   v_old = kp;
            r_n = b[0] ? dn : prevn; v_n = b[0] || kpn;
         end else begin
            r_thr = prev; r_old = prev; r_hold = prev; r_n = prevn;
            v_thr = kp; v_old = kp; v_hold = kp; v_n = kpn;
         end
      end
      e.e_thr = r_thr; e.e_old = r_old; e.e_hold = r_hold; e.e_n = r_n;
      e.v_thr = v_thr; e.v_old = v_old; e.v_hold = v_hold; e.v_n = v_n;
      e.tag = tag;
      scb.push_back(e);
   endtask

   initial begin
      #(CLK_PERIOD * 20000);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      for (int i = 0; i < (1<<AW); i++) begin m36[i] = '0; k36[i] = 0; end
      for (int i = 0; i < (1<<AWN); i++) begin mn[i] = '0; kn[i] = 0; end

      // R9: reset clears with ce low
      op(1, 0, 0, 4'hF, 9'd0, '0, 12'd0, 4'h0, "R9");
      op(1, 0, 0, 4'hF, 9'd0, '0, 12'd0, 4'h0, "R9");
      // R2 R6 R5: full writes; R1 top address and narrow ends
      op(0, 1, 1, 4'hF, 9'd5,   36'h1_2345_6789, 12'd0,    4'h3, "R2");
      op(0, 1, 1, 4'hF, 9'd9,   36'hF_0F0F_0F0F, 12'd4095, 4'hC, "R6");
      op(0, 1, 1, 4'hF, 9'd511, 36'hA_AAAA_5555, 12'd1,    4'h7, "R1");
      // R4: reads
      op(0, 1, 0, 4'hF, 9'd5,   '0, 12'd0,    4'h0, "R4");
      op(0, 1, 0, 4'hF, 9'd511, '0, 12'd4095, 4'h0, "R1");
      op(0, 1, 0, 4'hF, 9'd0,   '0, 12'd0,    4'h0, "R1");
      // R7 R5: rewrite and back-to-back rewrite of same word
      op(0, 1, 1, 4'hF, 9'd5, 36'h0_DEAD_BEEF, 12'd1, 4'h9, "R7");
      op(0, 1, 1, 4'hF, 9'd5, 36'h5_5AA5_3CC3, 12'd1, 4'h2, "R7");
      op(0, 1, 1, 4'hF, 9'd9, 36'h0_0000_0001, 12'd2, 4'h1, "R5");
      // R3: partial lanes on a known word
      op(0, 1, 1, 4'h5, 9'd5, 36'h1_1111_1111, 12'd1, 4'hE, "R3");
      op(0, 1, 0, 4'hF, 9'd5, '0, 12'd1, 4'h0, "R3");
      op(0, 1, 1, 4'hA, 9'd9, 36'hF_FFFF_FFFF, 12'd2, 4'h5, "R3");
      op(0, 1, 0, 4'hF, 9'd9, '0, 12'd2, 4'h0, "R3");
      // R8: ce low write is ignored, then read back shows no change
      op(0, 0, 1, 4'hF, 9'd9, 36'h0, 12'd2, 4'h0, "R8");
      op(0, 0, 0, 4'hF, 9'd5, 36'h0, 12'd1, 4'h0, "R8");
      op(0, 1, 0, 4'hF, 9'd9, '0, 12'd2, 4'h0, "R8");
      // R9: sync clear with ce low, then contents survive
      op(1, 0, 0, 4'hF, 9'd9, '0, 12'd2, 4'h0, "R9");
      op(0, 1, 0, 4'hF, 9'd5, '0, 12'd1, 4'h0, "R9");
      // R10: asynchronous clear between edges
      @(negedge clk);
      #1 rst = 1'b1;
      #1;
      check36("R10", "old async", q_old, '0);
      check36("R10", "narrow async", {32'd0, q_n}, 36'd0);
      check36("R9", "sync waits", q_thr, m36[5]);
      // R9: write during reset still stores
      op(1, 1, 1, 4'hF, 9'd3, 36'h7_7654_3210, 12'd3, 4'hB, "R9");
      op(0, 1, 0, 4'hF, 9'd3, '0, 12'd3, 4'h0, "R9");
      op(0, 1, 0, 4'hF, 9'd9, '0, 12'd4095, 4'h0, "R9");
      op(0, 0, 0, 4'hF, 9'd0, '0, 12'd0, 4'h0, "R8");
      @(negedge clk);
      @(negedge clk);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule